// File: doc/BRIEF.md
# Signed Right Shift Unit with Flag Updates

This block shifts a register value right arithmetically at one of four operand sizes (8, 16, 32 or 64 bits) and produces the flag updates a processor's integer datapath needs after such a shift. The operand has already been fetched. The shift count is an 8-bit value, taken from an immediate or from a count register. The block reduces the count to the range that applies to the selected size before it uses it. Bits that leave the operand at the low end are lost, except for the last one, which becomes the carry. The vacated upper bits are filled with copies of the sign.

Each flag comes out as three bits: a value, a write enable and an "undefined" marker. Downstream retire logic can then commit exactly the flags that the shift architecturally touches. A masked count of zero writes no flag and passes the operand through unchanged.

The outputs can be registered or combinational. A parameter selects which, and the registered form adds one cycle of latency with a valid strobe.

Top module: `sar_flag_unit`

## Requirements
- R1: The result equals the operand at the selected width shifted right by the masked count, with every vacated upper bit a copy of the operand's sign bit. The result therefore rounds toward negative infinity: at 32 bits, 0xFFFFFFF5 shifted by 2 gives 0xFFFFFFFD.
- R2: The `op_size` encoding is 0 = 8 bits, 1 = 16 bits, 2 = 32 bits and 3 = 64 bits. For sizes 0 to 2 only `count[4:0]` is used. For size 3 only `count[5:0]` is used. Higher count bits have no effect.
- R3: For a nonzero masked count, CF (flag bit 0) holds the last bit shifted out of the operand. When the masked count is at least the operand width, CF equals the sign bit and the result is all sign copies.
- R4: OF (flag bit 5) is written with value 0 whenever the masked count is nonzero. Its undefined marker is low for a masked count of 1 and high for a masked count greater than 1.
- R5: For a masked count of zero, all six flag write enables and all undefined markers are low, and the result equals the operand at the selected width.
- R6: SF (bit 4) is the result's bit at the selected width's top position. ZF (bit 3) is set when the result at the selected width is zero. Result bits above the selected width are driven 0.
- R7: PF (bit 1) is set when the low 8 bits of the result hold an even number of ones.
- R8: For a nonzero masked count, all six write enables are high. AF (bit 2) is then written with value 0 and its undefined marker is high.
- R9: With `REG_OUT` = 1, the outputs appear one clock after `in_valid`, and `out_valid` marks them. Synchronous reset clears `out_valid`, the result and all flag outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (used when outputs are registered) |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand and count are valid this cycle |
| op_size | input | 2 | Operand size select (0=8, 1=16, 2=32, 3=64 bits) |
| operand | input | 64 | Source value; bits above the selected width are ignored |
| count | input | 8 | Raw shift count before masking |
| out_valid | output | 1 | Result and flag outputs are valid |
| result | output | 64 | Shifted value, zero above the selected width |
| flag_val | output | 6 | Flag values {OF,SF,ZF,AF,PF,CF} |
| flag_wen | output | 6 | Per-flag write enable, same bit order |
| flag_undef | output | 6 | Per-flag undefined marker, same bit order |

## Verification
The bench builds the unit with `REG_OUT` = 1, so every vector passes through the output register. That makes the one-cycle latency, the valid strobe and the reset clearing of the outputs observable next to the datapath itself. Because the internal datapath is always 64 bits wide, this one build still reaches every operand size. It also reaches the counts that exceed the operand width, which occur only for 8- and 16-bit operands, and the count-masking boundaries at 32 and 64.

// File: rtl/sar_pkg.sv
package sar_pkg;

    localparam int unsigned DW    = 64;
    localparam int unsigned CW    = 8;
    localparam int unsigned MCW   = $clog2(DW);
    localparam int unsigned NFL   = 6;

    localparam int unsigned FL_CF = 0;
    localparam int unsigned FL_PF = 1;
    localparam int unsigned FL_AF = 2;
    localparam int unsigned FL_ZF = 3;
    localparam int unsigned FL_SF = 4;
    localparam int unsigned FL_OF = 5;

    typedef enum logic [1:0] {
        SZ_B = 2'd0,
        SZ_W = 2'd1,
        SZ_D = 2'd2,
        SZ_Q = 2'd3
    } opsz_e;

    typedef struct packed {
        logic [DW-1:0]  res;
        logic [NFL-1:0] val;
        logic [NFL-1:0] wen;
        logic [NFL-1:0] undef;
    } sar_out_t;

    function automatic logic [DW-1:0] width_mask(opsz_e sz);
        case (sz)
            SZ_B:    return {{(DW-8){1'b0}},  {8{1'b1}}};
            SZ_W:    return {{(DW-16){1'b0}}, {16{1'b1}}};
            SZ_D:    return {{(DW-32){1'b0}}, {32{1'b1}}};
            default: return {DW{1'b1}};
        endcase
    endfunction

    function automatic logic top_bit(opsz_e sz, logic [DW-1:0] d);
        case (sz)
            SZ_B:    return d[7];
            SZ_W:    return d[15];
            SZ_D:    return d[31];
            default: return d[DW-1];
        endcase
    endfunction

    function automatic logic [MCW-1:0] mask_count(opsz_e sz, logic [CW-1:0] raw);
        if (sz == SZ_Q)
            return raw[MCW-1:0];
        return {1'b0, raw[MCW-2:0]};
    endfunction

endpackage

// File: rtl/sar_count_mask.sv
module sar_count_mask
    import sar_pkg::*;
(
    input  opsz_e              sz,
    input  logic [CW-1:0]      cnt_raw,
    output logic [MCW-1:0]     cnt,
    output logic               cnt_zero,
    output logic               cnt_one
);
    always_comb begin
        cnt      = mask_count(sz, cnt_raw);
        cnt_zero = (cnt == '0);
        cnt_one  = (cnt == MCW'(1));
    end
endmodule

// File: rtl/sar_shift_core.sv
module sar_shift_core
    import sar_pkg::*;
(
    input  opsz_e              sz,
    input  logic [DW-1:0]      data,
    input  logic [MCW-1:0]     cnt,
    output logic [DW-1:0]      res,
    output logic               carry
);
    logic [DW-1:0]        sx;
    logic signed [DW:0]   wide;
    logic signed [DW:0]   shifted;

    always_comb begin
        case (sz)
            SZ_B:    sx = {{(DW-8){data[7]}},   data[7:0]};
            SZ_W:    sx = {{(DW-16){data[15]}}, data[15:0]};
            SZ_D:    sx = {{(DW-32){data[31]}}, data[31:0]};
            default: sx = data;
        endcase
        wide    = {sx, 1'b0};
        shifted = wide >>> cnt;
        res     = shifted[DW:1] & width_mask(sz);
        carry   = shifted[0];
    end
endmodule

// File: rtl/sar_flag_gen.sv
module sar_flag_gen
    import sar_pkg::*;
(
    input  opsz_e              sz,
    input  logic [DW-1:0]      res,
    input  logic               carry,
    input  logic               cnt_zero,
    input  logic               cnt_one,
    output logic [NFL-1:0]     val,
    output logic [NFL-1:0]     wen,
    output logic [NFL-1:0]     undef
);
    always_comb begin
        val        = '0;
        wen        = '0;
        undef      = '0;
        if (!cnt_zero) begin
            wen          = '1;
            val[FL_CF]   = carry;
            val[FL_PF]   = ~^res[7:0];
            val[FL_AF]   = 1'b0;
            val[FL_ZF]   = ((res & width_mask(sz)) == '0);
            val[FL_SF]   = top_bit(sz, res);
            val[FL_OF]   = 1'b0;
            undef[FL_AF] = 1'b1;
            undef[FL_OF] = !cnt_one;
        end
    end
endmodule

// File: rtl/sar_flag_unit.sv
module sar_flag_unit
    import sar_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [1:0]        op_size,
    input  logic [63:0]       operand,
    input  logic [7:0]        count,
    output logic              out_valid,
    output logic [63:0]       result,
    output logic [5:0]        flag_val,
    output logic [5:0]        flag_wen,
    output logic [5:0]        flag_undef
);
    opsz_e            sz;
    logic [MCW-1:0]   cnt;
    logic             cnt_zero;
    logic             cnt_one;
    logic [DW-1:0]    sh_res;
    logic             sh_carry;
    sar_out_t         nxt;

    assign sz = opsz_e'(op_size);

    sar_count_mask u_mask (
        .sz       (sz),
        .cnt_raw  (count),
        .cnt      (cnt),
        .cnt_zero (cnt_zero),
        .cnt_one  (cnt_one)
    );

    sar_shift_core u_core (
        .sz    (sz),
        .data  (operand),
        .cnt   (cnt),
        .res   (sh_res),
        .carry (sh_carry)
    );

    sar_flag_gen u_flags (
        .sz       (sz),
        .res      (sh_res),
        .carry    (sh_carry),
        .cnt_zero (cnt_zero),
        .cnt_one  (cnt_one),
        .val      (nxt.val),
        .wen      (nxt.wen),
        .undef    (nxt.undef)
    );

    assign nxt.res = sh_res;

    generate
        if (REG_OUT) begin : g_reg
            sar_out_t q;
            logic     q_v;
            always_ff @(posedge clk) begin
                if (rst) begin
                    q   <= '0;
                    q_v <= 1'b0;
                end else begin
                    q_v <= in_valid;
                    if (in_valid)
                        q <= nxt;
                end
            end
            assign out_valid  = q_v;
            assign result     = q.res;
            assign flag_val   = q.val;
            assign flag_wen   = q.wen;
            assign flag_undef = q.undef;
        end else begin : g_comb
            assign out_valid  = in_valid;
            assign result     = nxt.res;
            assign flag_val   = nxt.val;
            assign flag_wen   = nxt.wen;
            assign flag_undef = nxt.undef;
        end
    endgenerate

endmodule

// File: rtl/sar_flag_unit_chk.sv
module sar_flag_unit_chk
    import sar_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [1:0]        op_size,
    input  logic [63:0]       operand,
    input  logic [7:0]        count,
    input  logic              out_valid,
    input  logic [63:0]       result,
    input  logic [5:0]        flag_val,
    input  logic [5:0]        flag_wen,
    input  logic [5:0]        flag_undef
);
    logic          c_v;
    opsz_e         c_sz;
    logic [DW-1:0] c_op;
    logic [CW-1:0] c_cnt;
    logic [MCW-1:0] m_cnt;

    generate
        if (REG_OUT) begin : g_cap
            always_ff @(posedge clk) begin
                if (rst) begin
                    c_v   <= 1'b0;
                    c_sz  <= SZ_B;
                    c_op  <= '0;
                    c_cnt <= '0;
                end else begin
                    c_v <= in_valid;
                    if (in_valid) begin
                        c_sz  <= opsz_e'(op_size);
                        c_op  <= operand;
                        c_cnt <= count;
                    end
                end
            end

            p_valid_follows_r9: assert property (@(posedge clk) disable iff (rst)
                in_valid |=> out_valid);
            p_idle_no_valid_r9: assert property (@(posedge clk) disable iff (rst)
                !in_valid |=> !out_valid);
        end else begin : g_pass
            assign c_v   = in_valid;
            assign c_sz  = opsz_e'(op_size);
            assign c_op  = operand;
            assign c_cnt = count;
        end
    endgenerate

    assign m_cnt = (c_sz == SZ_Q) ? c_cnt[MCW-1:0] : {1'b0, c_cnt[MCW-2:0]};

    p_sign_kept_r1: assert property (@(posedge clk) disable iff (rst)
        (c_v && flag_wen[FL_SF]) |-> (flag_val[FL_SF] == top_bit(c_sz, c_op)));

    p_carry_one_r3: assert property (@(posedge clk) disable iff (rst)
        (c_v && m_cnt == MCW'(1)) |-> (flag_val[FL_CF] == c_op[0]));

    p_of_defined_r4: assert property (@(posedge clk) disable iff (rst)
        (c_v && m_cnt == MCW'(1)) |-> (flag_wen[FL_OF] && !flag_val[FL_OF] && !flag_undef[FL_OF]));

    p_zero_count_r5: assert property (@(posedge clk) disable iff (rst)
        (c_v && m_cnt == '0) |-> (flag_wen == '0 && flag_undef == '0 &&
                                  result == (c_op & width_mask(c_sz))));

    p_upper_clear_r6: assert property (@(posedge clk) disable iff (rst)
        c_v |-> ((result & ~width_mask(c_sz)) == '0));

    p_af_undef_r8: assert property (@(posedge clk) disable iff (rst)
        (c_v && m_cnt != '0) |-> (flag_wen == 6'h3F && flag_undef[FL_AF] && !flag_val[FL_AF]));

endmodule

bind sar_flag_unit sar_flag_unit_chk #(.REG_OUT(REG_OUT)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .op_size    (op_size),
    .operand    (operand),
    .count      (count),
    .out_valid  (out_valid),
    .result     (result),
    .flag_val   (flag_val),
    .flag_wen   (flag_wen),
    .flag_undef (flag_undef)
);

// File: tb/tb_sar_flag_unit.sv
module tb_sar_flag_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [1:0]  op_size = 2'd0;
    logic [63:0] operand = '0;
    logic [7:0]  count = '0;
    logic        out_valid;
    logic [63:0] result;
    logic [5:0]  flag_val, flag_wen, flag_undef;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    sar_flag_unit #(.REG_OUT(1'b1)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_size(op_size),
        .operand(operand), .count(count), .out_valid(out_valid),
        .result(result), .flag_val(flag_val), .flag_wen(flag_wen),
        .flag_undef(flag_undef)
    );

    // {size, operand, count, expected result}
    localparam int NV = 10;
    localparam logic [137:0] VEC [NV] = '{
        {2'd2, 64'h0000_0000_FFFF_FFF5, 8'd2,    64'h0000_0000_FFFF_FFFD}, // R1
        {2'd0, 64'hFFFF_FF00_0000_0080, 8'd1,    64'h0000_0000_0000_00C0}, // R6 upper ignored
        {2'd0, 64'h0000_0000_0000_007F, 8'd7,    64'h0000_0000_0000_0000},
        {2'd1, 64'h0000_0000_0000_8000, 8'd16,   64'h0000_0000_0000_FFFF}, // R3 cnt==width
        {2'd3, 64'h8000_0000_0000_0000, 8'd63,   64'hFFFF_FFFF_FFFF_FFFF},
        {2'd3, 64'h0123_4567_89AB_CDEF, 8'h40,   64'h0123_4567_89AB_CDEF}, // R2 mask -> 0
        {2'd2, 64'h0000_0000_0000_0006, 8'h21,   64'h0000_0000_0000_0003}, // R2 mask -> 1
        {2'd0, 64'h0000_0000_0000_0055, 8'h20,   64'h0000_0000_0000_0055}, // R5
        {2'd2, 64'h0000_0000_4000_0000, 8'd31,   64'h0000_0000_0000_0000},
        {2'd1, 64'h0000_0000_0000_7FFF, 8'd20,   64'h0000_0000_0000_0000}
    };

    function automatic logic [63:0] ref_res(logic [1:0] sz, logic [63:0] op, int c);
        logic signed [7:0]  t8;
        logic signed [15:0] t16;
        logic signed [31:0] t32;
        logic signed [63:0] t64;
        case (sz)
            2'd0: begin t8  = $signed(op[7:0])  >>> c; return {56'd0, t8}; end
            2'd1: begin t16 = $signed(op[15:0]) >>> c; return {48'd0, t16}; end
            2'd2: begin t32 = $signed(op[31:0]) >>> c; return {32'd0, t32}; end
            default: begin t64 = $signed(op) >>> c; return t64; end
        endcase
    endfunction

    function automatic int wid(logic [1:0] sz);
        return (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : (sz == 2'd2) ? 32 : 64;
    endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_one(logic [1:0] sz, logic [63:0] op, logic [7:0] cnt,
                           bit use_exp, logic [63:0] exp_res);
        int c, w;
        logic [63:0] r;
        logic [5:0] ev, ew, eu;
        logic cf;
        w = wid(sz);
        c = (sz == 2'd3) ? int'(cnt[5:0]) : int'(cnt[4:0]);
        r = ref_res(sz, op, c);
        if (c == 0) cf = 1'b0;
        else if (c <= w) cf = op[c-1];
        else cf = op[w-1];
        ev = '0; ew = '0; eu = '0;
        if (c != 0) begin
            ew = 6'h3F;
            ev[0] = cf;
            ev[1] = ~^r[7:0];
            ev[3] = (r == 64'd0);
            ev[4] = r[w-1];
            eu[2] = 1'b1;
            eu[5] = (c > 1);
        end
        @(negedge clk);
        in_valid = 1'b1; op_size = sz; operand = op; count = cnt;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R9 out_valid", {63'd0, out_valid}, 64'd1);
        if (use_exp) chk("R1 table result", result, exp_res);
        chk("R1 R6 result", result, r);
        chk("R3 R7 R6 flag_val", {58'd0, flag_val}, {58'd0, ev});
        chk("R5 R8 flag_wen", {58'd0, flag_wen}, {58'd0, ew});
        chk("R4 R8 flag_undef", {58'd0, flag_undef}, {58'd0, eu});
    endtask

    initial begin
        #400000;
        if (!finished) begin
            checks++; failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9 reset out_valid", {63'd0, out_valid}, 64'd0);
        chk("R9 reset result", result, 64'd0);
        chk("R9 reset flags", {46'd0, flag_val, flag_wen, flag_undef}, 64'd0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++)
            run_one(VEC[i][137:136], VEC[i][135:72], VEC[i][71:64], 1'b1, VEC[i][63:0]);

        // Count corners per size: 0, 1, width-1, width, 31, 63, plus high bits set (R2)
        for (int s = 0; s < 4; s++) begin
            for (int k = 0; k < 8; k++) begin
                int w;
                logic [7:0] cc;
                w = wid(2'(s));
                case (k)
                    0: cc = 8'd0;
                    1: cc = 8'd1;
                    2: cc = 8'(w - 1);
                    3: cc = 8'(w);
                    4: cc = 8'd31;
                    5: cc = 8'd63;
                    6: cc = 8'hE1;
                    default: cc = 8'hC0;
                endcase
                run_one(2'(s), {$urandom, $urandom}, cc, 1'b0, '0);
                run_one(2'(s), 64'h8000_8080_8000_0080 | {$urandom, $urandom}, cc, 1'b0, '0);
            end
        end

        // Random sweep
        for (int i = 0; i < 400; i++)
            run_one(2'($urandom), {$urandom, $urandom}, 8'($urandom), 1'b0, '0);

        // R9: idle cycle drops out_valid
        @(negedge clk);
        chk("R9 idle out_valid", {63'd0, out_valid}, 64'd0);

        // R9: reset clears held outputs
        run_one(2'd3, 64'hF000_0000_0000_0001, 8'd4, 1'b0, '0);
        rst = 1'b1;
        @(negedge clk);
        chk("R9 reset clears result", result, 64'd0);
        chk("R9 reset clears wen", {58'd0, flag_wen}, 64'd0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule